// File: doc/BRIEF.md
# Pulse Add/Delete Clock Divider

This block is the pulse-steering stage of an all-digital phase-locked loop. Left alone, it halves its input clock. It emits a one-cycle-wide qualifier pulse on every second input clock. Correction requests come from an up/down counter stage. A carry request makes the block emit one extra pulse. A borrow request makes it swallow one pulse. Each correction moves the phase of the output stream by half an output period. The output feeds an external divide-by-N counter, which closes the loop.

The carry and borrow requests may come from logic on another clock. They pass through a chain of capture registers, with a depth set by `SYNC_STAGES`. A rising-edge detector then turns each request into a single event, however long the request level lasts. Events wait in pending flags until the next suitable slot:

- An added pulse goes into the empty half of the toggle cycle.
- A deletion blanks the next scheduled pulse.

Over a window of input clocks, the pulse count equals half the window, plus the carries, minus the borrows.

Top module: `pulse_adjust_divider`

## Requirements
- R1: With no requests, `pulse_o` is high for exactly one input clock out of every two, so a window of 64 clocks holds exactly 32 pulses.
- R2: Each rising edge of `carry_i` adds exactly one pulse. The pulse is placed in the next otherwise-empty slot, and the regular pulses stay where they are.
- R3: Each rising edge of `borrow_i` removes exactly one pulse, namely the next scheduled pulse.
- R4: With carry and borrow events spaced at least four clocks apart, the pulse count over a window is 32 + carries − borrows for a 64-clock window.
- R5: A request level held high for many clocks counts as one event only.
- R6: A carry event and a borrow event pending in the same cycle cancel each other. Both are dropped, and the output keeps its regular pattern.
- R7: While `rst_n` is low, `pulse_o` is 0 and all pending events are cleared. An event raised just before reset has no effect after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, twice the nominal output rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| carry_i | input | 1 | Add-a-pulse request; its rising edge counts |
| borrow_i | input | 1 | Remove-a-pulse request; its rising edge counts |
| pulse_o | output | 1 | Output pulse qualifier, high one clock per emitted pulse |

## Verification
The add path and the remove path can both act in the same cycle: a carry and a borrow can become pending together. The bench provokes this by raising `carry_i` and `borrow_i` on the same clock, both for a single clock and with both levels held high. It judges the result by the pulse count over a 64-clock window, which must stay at exactly 32. Mixed sequences, with carries and borrows raised on separate clocks, check that the two paths still add up independently when they do not coincide.

// File: rtl/pad_div_pkg.sv
package pad_div_pkg;

    // Registered state of the divider core
    typedef struct packed {
        logic phase;     // 0: empty slot next, 1: scheduled slot next
        logic add_pend;  // carry event waiting for an empty slot
        logic del_pend;  // borrow event waiting for a scheduled slot
        logic pulse;     // registered output qualifier
    } pad_state_t;

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int CHAIN_W = W * STAGES;

    logic [CHAIN_W-1:0] chain_d;
    logic [CHAIN_W-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = din;
        end else begin : g_multi
            always_comb chain_d = {chain_q[CHAIN_W-W-1:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[CHAIN_W-1 -: W];

endmodule

// File: rtl/pad_edge.sv
module pad_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d;
    logic [W-1:0] prev_q;

    always_comb prev_d = level_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end

    assign rise_o = level_i & ~prev_q;

    // A held level may yield only one event
    generate
        for (genvar i = 0; i < W; i++) begin : g_chk
            assert_single_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
                rise_o[i] |=> !rise_o[i]);
        end
    endgenerate

endmodule

// File: rtl/pulse_adjust_divider.sv
module pulse_adjust_divider
    import pad_div_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carry_i,
    input  logic borrow_i,
    output logic pulse_o
);
    localparam int REQ_W = 2;  // bit 0: carry, bit 1: borrow

    logic [REQ_W-1:0] req_sync;
    logic [REQ_W-1:0] req_rise;
    logic             add_now;
    logic             del_now;
    pad_state_t       st_d;
    pad_state_t       st_q;

    pad_sync #(.W(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({borrow_i, carry_i}),
        .dout  (req_sync)
    );

    pad_edge #(.W(REQ_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (req_sync),
        .rise_o  (req_rise)
    );

    assign add_now = st_q.add_pend | req_rise[0];
    assign del_now = st_q.del_pend | req_rise[1];

    always_comb begin
        st_d          = st_q;
        st_d.phase    = ~st_q.phase;
        st_d.add_pend = add_now;
        st_d.del_pend = del_now;
        st_d.pulse    = st_q.phase;
        if (add_now && del_now) begin
            // opposing corrections annul each other
            st_d.add_pend = 1'b0;
            st_d.del_pend = 1'b0;
        end else if (!st_q.phase) begin
            if (add_now) begin
                st_d.pulse    = 1'b1;
                st_d.add_pend = 1'b0;
            end
        end else begin
            if (del_now) begin
                st_d.pulse    = 1'b0;
                st_d.del_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    assert_empty_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.phase && !(add_now && !del_now)) |=> !pulse_o);

    assert_insert_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.phase && add_now && !del_now) |=> (pulse_o && !st_q.add_pend));

    assert_delete_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase && del_now && !add_now) |=> (!pulse_o && !st_q.del_pend));

    assert_sched_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase && !(del_now && !add_now)) |=> pulse_o);

    assert_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (add_now && del_now) |=> (!st_q.add_pend && !st_q.del_pend));

endmodule

// File: tb/pulse_adjust_divider_tb.sv
module pulse_adjust_divider_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WIN        = 64;
    localparam int BASE       = WIN / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic carry_i = 1'b0;
    logic borrow_i = 1'b0;
    logic pulse_o;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    pulse_adjust_divider #(.SYNC_STAGES(2)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .carry_i  (carry_i),
        .borrow_i (borrow_i),
        .pulse_o  (pulse_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; carry_i = 1'b0; borrow_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Count pulses over a window; carry/borrow trains given by start, gap, length, count
    task automatic run_window(input int a_st, input int a_gap, input int a_len, input int a_n,
                              input int d_st, input int d_gap, input int d_len, input int d_n,
                              output int cnt);
        cnt = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            cnt += int'(pulse_o);
            carry_i  = (a_n > 0 && i >= a_st && ((i - a_st) % a_gap) < a_len && ((i - a_st) / a_gap) < a_n);
            borrow_i = (d_n > 0 && i >= d_st && ((i - d_st) % d_gap) < d_len && ((i - d_st) / d_gap) < d_n);
        end
        carry_i = 1'b0; borrow_i = 1'b0;
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R7 output low in reset", int'(pulse_o), 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 first slot after reset empty", int'(pulse_o), 0);
    endtask

    task automatic t_idle();
        int c;
        do_reset();
        run_window(0, 1, 0, 0, 0, 1, 0, 0, c);
        check("R1 idle half rate", c, BASE);
        run_window(0, 1, 0, 0, 0, 1, 0, 0, c);
        check("R1 idle second window", c, BASE);
    endtask

    task automatic t_add();
        int c;
        do_reset();
        run_window(10, 8, 1, 1, 0, 1, 0, 0, c);
        check("R2 one carry", c, BASE + 1);
        run_window(5, 8, 1, 3, 0, 1, 0, 0, c);
        check("R2 three carries", c, BASE + 3);
    endtask

    task automatic t_del();
        int c;
        do_reset();
        run_window(0, 1, 0, 0, 11, 8, 1, 1, c);
        check("R3 one borrow", c, BASE - 1);
        run_window(0, 1, 0, 0, 4, 9, 1, 3, c);
        check("R3 three borrows", c, BASE - 3);
    endtask

    task automatic t_long_level();
        int c;
        do_reset();
        run_window(6, 40, 14, 1, 0, 1, 0, 0, c);
        check("R5 long carry level once", c, BASE + 1);
        run_window(0, 1, 0, 0, 6, 40, 14, 1, c);
        check("R5 long borrow level once", c, BASE - 1);
    endtask

    task automatic t_same_cycle();
        int c;
        do_reset();
        run_window(12, 8, 1, 1, 12, 8, 1, 1, c);
        check("R6 carry and borrow together cancel", c, BASE);
        run_window(9, 8, 1, 2, 9, 8, 1, 2, c);
        check("R6 two coincident pairs cancel", c, BASE);
        run_window(7, 40, 10, 1, 7, 40, 10, 1, c);
        check("R6 coincident held levels cancel", c, BASE);
    endtask

    task automatic t_mixed();
        int c;
        do_reset();
        run_window(4, 10, 1, 2, 30, 8, 1, 1, c);
        check("R4 two carries one borrow", c, BASE + 1);
        run_window(6, 8, 1, 1, 20, 8, 1, 3, c);
        check("R4 one carry three borrows", c, BASE - 2);
    endtask

    task automatic t_reset_clears();
        int c;
        do_reset();
        @(negedge clk); carry_i = 1'b1;
        @(negedge clk); carry_i = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        run_window(0, 1, 0, 0, 0, 1, 0, 0, c);
        check("R7 event before reset discarded", c, BASE);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_idle();
        t_add();
        t_del();
        t_long_level();
        t_same_cycle();
        t_mixed();
        t_reset_clears();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule